// File: doc/BRIEF.md
# Program memory external interface

This block connects a processor core to external 24-bit program memory. The core holds only 16-bit data registers, so the block keeps an 8-bit extension register that makes up the difference. On a data write, the 16-bit value becomes the upper part of the memory word and the extension register supplies the low byte. On a data read, the upper 16 bits go back to the core and the low byte is kept in the extension register. Instruction fetches move the whole 24-bit word and leave the extension register alone.

Each access drives a 14-bit address, a memory select and one read or write strobe, all active low. The strobes are held for one cycle plus a programmable number of wait states, from 0 to 7. After reset the setting is 7. The read strobe also acts as the output enable of the external device. A write cycle drives the bidirectional data bus, and `pm_dout_en` reports this so that an external transceiver can follow it. Every access is followed by at least one idle cycle. The core issues a request only while `idle` is high and takes the result when `rsp_ready` is high.

Top module: `pmem_xbus`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pm_sel_n`, `pm_rd_n` and `pm_wr_n` are high, `pm_dout_en` is low, `idle` is high and `xreg_q` is 0.
- R2: During every cycle of a data write (`req_write`=1), `pm_data` carries `{req_wdata, xreg_q}`: the data in bits 23:8 and the extension byte in bits 7:0.
- R3: On a data read (`req_write`=0, `req_fetch`=0), `rsp_rdata` in the final cycle equals `{8'h00, pm_data[23:8]}`. The extension register then holds `pm_data[7:0]` from that cycle.
- R4: On an instruction fetch (`req_write`=0, `req_fetch`=1), `rsp_rdata` in the final cycle equals all 24 bits of `pm_data`, and `xreg_q` is unchanged.
- R5: With a wait-state setting N, the select and the strobe stay low for exactly N+1 consecutive cycles, starting in the cycle after the request is accepted. `rsp_ready` is high only in the last of those cycles.
- R6: The wait-state setting resets to 7. A `ws_set_vld` pulse loads `ws_set_val` (0..7), and the new value applies to every access accepted afterwards.
- R7: `pm_sel_n` is low in every cycle in which `pm_rd_n` or `pm_wr_n` is low, and the two strobes are never low together.
- R8: `pm_dout_en` is high, and the block drives `pm_data`, only in cycles in which `pm_wr_n` is low.
- R9: After the final cycle of an access, the select and both strobes are high for at least one cycle before the next access starts, even if a request is held.
- R10: A request presented while `idle` is low is ignored and starts no access.
- R11: `pm_addr` holds the accepted `req_addr` in every cycle of an access.
- R12: An `xreg_ld` pulse while `idle` is high loads `xreg_wval` into the extension register. A pulse while `idle` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_set_vld | input | 1 | Load the wait-state setting |
| ws_set_val | input | 3 | New wait-state count, 0..7 |
| xreg_ld | input | 1 | Core load of the extension register |
| xreg_wval | input | 8 | Value for the extension register |
| xreg_q | output | 8 | Extension register contents |
| req_vld | input | 1 | Access request from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | 14 | Program memory address |
| req_wdata | input | 16 | Data register value for writes |
| idle | output | 1 | Block can accept a request |
| rsp_ready | output | 1 | Final cycle of the access |
| rsp_rdata | output | 24 | Read result, valid with rsp_ready |
| pm_addr | output | 14 | External address |
| pm_data | inout | 24 | External data bus |
| pm_dout_en | output | 1 | Block is driving pm_data |
| pm_sel_n | output | 1 | Program memory select, active low |
| pm_rd_n | output | 1 | Read strobe / output enable, active low |
| pm_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 14-bit address, a 16-bit data register, a 24-bit word and a 3-bit wait-state field that resets to 7. Because the field is 3 bits wide, every setting from 0 up to the reset value of 7 can be reached. The bench covers the single-cycle case, the longest strobe, and several settings in between, each across writes, data reads and fetches. A held request shows the forced idle gap between accesses. Stray requests and extension loads made during an access show that both are ignored while the block is busy.

// File: rtl/pmem_xbus_pkg.sv
package pmem_xbus_pkg;

    typedef enum logic [1:0] {
        PX_IDLE = 2'd0,
        PX_ACT  = 2'd1,
        PX_GAP  = 2'd2
    } px_state_e;

    typedef struct packed {
        logic write;
        logic fetch;
    } px_kind_t;

    function automatic logic is_data_read(input px_kind_t k);
        return !k.write && !k.fetch;
    endfunction

endpackage

// File: rtl/pmx_wait_ctr.sv
module pmx_wait_ctr #(
    parameter int WS_W   = 3,
    parameter int WS_RST = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_vld,
    input  logic [WS_W-1:0] set_val,
    input  logic            load,
    input  logic            run,
    output logic            last
);
    localparam logic [WS_W-1:0] WS_INIT = WS_W'(WS_RST);

    logic [WS_W-1:0] ws_q;
    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          ws_q <= WS_INIT;
        else if (set_vld) ws_q <= set_val;
    end

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= ws_q;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    AST_CNT_WITHIN_SETTING: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(ws_q)))  // R6
        else $error("AST_CNT_WITHIN_SETTING");
endmodule

// File: rtl/pmx_ext_reg.sv
module pmx_ext_reg #(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_ld,
    input  logic [EXT_W-1:0] core_val,
    input  logic             cap,
    input  logic [EXT_W-1:0] cap_val,
    output logic [EXT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (cap)     q <= cap_val;
        else if (core_ld) q <= core_val;
    end

    AST_CAPTURE_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        cap |=> (q == $past(cap_val)))  // R3
        else $error("AST_CAPTURE_LOW_BYTE");
endmodule

// File: rtl/pmx_seq.sv
module pmx_seq
    import pmem_xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_vld,
    input  logic      last,
    output logic      accept,
    output logic      active,
    output logic      idle
);
    px_state_e st_q, st_d;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q)
            PX_IDLE: if (req_vld) begin
                st_d   = PX_ACT;
                accept = 1'b1;
            end
            PX_ACT:  if (last) st_d = PX_GAP;
            PX_GAP:  st_d = PX_IDLE;
            default: st_d = PX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PX_IDLE;
        else     st_q <= st_d;
    end

    assign active = (st_q == PX_ACT);
    assign idle   = (st_q == PX_IDLE);

    AST_GAP_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (active && last) |=> !active && !idle)  // R9
        else $error("AST_GAP_FOLLOWS_ACCESS");
endmodule

// File: rtl/pmem_xbus.sv
module pmem_xbus
    import pmem_xbus_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int WORD_W = 24,
    parameter int WS_W   = 3,
    parameter int WS_RST = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ws_set_vld,
    input  logic [WS_W-1:0]     ws_set_val,
    input  logic                xreg_ld,
    input  logic [WORD_W-DATA_W-1:0] xreg_wval,
    output logic [WORD_W-DATA_W-1:0] xreg_q,
    input  logic                req_vld,
    input  logic                req_write,
    input  logic                req_fetch,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                idle,
    output logic                rsp_ready,
    output logic [WORD_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   pm_addr,
    inout  wire  [WORD_W-1:0]   pm_data,
    output logic                pm_dout_en,
    output logic                pm_sel_n,
    output logic                pm_rd_n,
    output logic                pm_wr_n
);
    localparam int EXT_W = WORD_W - DATA_W;

    logic              accept, active, last;
    px_kind_t          kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wword_q;
    logic              cap;

    pmx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_vld (req_vld),
        .last    (last),
        .accept  (accept),
        .active  (active),
        .idle    (idle)
    );

    pmx_wait_ctr #(.WS_W(WS_W), .WS_RST(WS_RST)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .set_vld (ws_set_vld),
        .set_val (ws_set_val),
        .load    (accept),
        .run     (active),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= '0;
            addr_q  <= '0;
            wword_q <= '0;
        end else if (accept) begin
            kind_q  <= '{write: req_write, fetch: req_fetch};
            addr_q  <= req_addr;
            wword_q <= {req_wdata, xreg_q};
        end
    end

    assign cap = active && last && is_data_read(kind_q);

    pmx_ext_reg #(.EXT_W(EXT_W)) u_xreg (
        .clk      (clk),
        .rst      (rst),
        .core_ld  (xreg_ld && idle),
        .core_val (xreg_wval),
        .cap      (cap),
        .cap_val  (pm_data[EXT_W-1:0]),
        .q        (xreg_q)
    );

    assign pm_addr    = addr_q;
    assign pm_sel_n   = !active;
    assign pm_rd_n    = !(active && !kind_q.write);
    assign pm_wr_n    = !(active && kind_q.write);
    assign pm_dout_en = active && kind_q.write;
    assign pm_data    = pm_dout_en ? wword_q : {WORD_W{1'bz}};
    assign rsp_ready  = active && last;

    always_comb begin
        if (kind_q.write)      rsp_rdata = '0;
        else if (kind_q.fetch) rsp_rdata = pm_data;
        else                   rsp_rdata = {{EXT_W{1'b0}}, pm_data[WORD_W-1:EXT_W]};
    end

    AST_SEL_QUALIFIES_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!pm_rd_n || !pm_wr_n) |-> !pm_sel_n)  // R7
        else $error("AST_SEL_QUALIFIES_STROBE");
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!pm_rd_n && !pm_wr_n))  // R7
        else $error("AST_STROBES_EXCLUSIVE");
    AST_DRIVE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        pm_dout_en |-> !pm_wr_n)  // R8
        else $error("AST_DRIVE_ONLY_ON_WRITE");
    AST_READY_INSIDE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> !pm_sel_n)  // R5
        else $error("AST_READY_INSIDE_ACCESS");
    AST_IDLE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> pm_sel_n && pm_rd_n && pm_wr_n)  // R9
        else $error("AST_IDLE_AFTER_READY");
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!pm_sel_n && $past(!pm_sel_n)) |-> $stable(pm_addr))  // R11
        else $error("AST_ADDR_HELD");
    AST_FETCH_KEEPS_XREG: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && kind_q.fetch) |=> $stable(xreg_q))  // R4
        else $error("AST_FETCH_KEEPS_XREG");
endmodule

// File: tb/sim_pmem_xbus.sv
module sim_pmem_xbus;
    typedef struct packed {
        logic        wr;
        logic        fe;
        logic        set_ws;
        logic        ld_x;
        logic [2:0]  ws;
        logic [13:0] addr;
        logic [15:0] wdata;
        logic [7:0]  xin;
        logic [23:0] mem;
        logic [23:0] exp_data;
        logic [7:0]  exp_x;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 14'h0123, 16'hBEEF, 8'h5A, 24'h000000, 24'hBEEF5A, 8'h5A},
        '{1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 14'h3FFF, 16'h0000, 8'hA5, 24'h123456, 24'h001234, 8'h56},
        '{1'b0, 1'b1, 1'b1, 1'b1, 3'd7, 14'h0800, 16'h0000, 8'h33, 24'hFEDCBA, 24'hFEDCBA, 8'h33},
        '{1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 14'h2AAA, 16'h0001, 8'hFF, 24'h000000, 24'h0001FF, 8'hFF},
        '{1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 14'h0000, 16'h0000, 8'h00, 24'hA0B0C0, 24'h00A0B0, 8'hC0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 14'h1555, 16'h7E7E, 8'h00, 24'h000000, 24'h7E7EC0, 8'hC0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ws_set_vld = 1'b0;
    logic [2:0]  ws_set_val = '0;
    logic        xreg_ld = 1'b0;
    logic [7:0]  xreg_wval = '0;
    logic [7:0]  xreg_q;
    logic        req_vld = 1'b0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [13:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        idle, rsp_ready;
    logic [23:0] rsp_rdata;
    logic [13:0] pm_addr;
    wire  [23:0] pm_bus;
    logic        pm_dout_en, pm_sel_n, pm_rd_n, pm_wr_n;
    logic [23:0] mem_word = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign pm_bus = (!pm_sel_n && !pm_rd_n) ? mem_word : 24'hzzzzzz;

    pmem_xbus u0 (
        .clk(clk), .rst(rst),
        .ws_set_vld(ws_set_vld), .ws_set_val(ws_set_val),
        .xreg_ld(xreg_ld), .xreg_wval(xreg_wval), .xreg_q(xreg_q),
        .req_vld(req_vld), .req_write(req_write), .req_fetch(req_fetch),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .idle(idle), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .pm_addr(pm_addr), .pm_data(pm_bus), .pm_dout_en(pm_dout_en),
        .pm_sel_n(pm_sel_n), .pm_rd_n(pm_rd_n), .pm_wr_n(pm_wr_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One access: optional xreg load and wait-state programming, then the request.
    task automatic run_access(input vec_t v, input bit stray);
        if (v.ld_x) begin
            xreg_ld = 1'b1; xreg_wval = v.xin;
            @(negedge clk);
            xreg_ld = 1'b0;
            chk(xreg_q == v.xin, "R12 load while idle", xreg_q, v.xin);
        end
        if (v.set_ws) begin
            ws_set_vld = 1'b1; ws_set_val = v.ws;
            @(negedge clk);
            ws_set_vld = 1'b0;
        end
        mem_word = v.mem;
        chk(idle == 1'b1, "R10 idle before request", idle, 1);
        req_vld = 1'b1; req_write = v.wr; req_fetch = v.fe;
        req_addr = v.addr; req_wdata = v.wdata;
        @(negedge clk);
        req_vld = 1'b0;
        for (int k = 0; k <= int'(v.ws); k++) begin
            if (stray && k == 0) begin
                req_vld = 1'b1; req_addr = 14'h0777; req_write = 1'b1;
                xreg_ld = 1'b1; xreg_wval = 8'h99;
            end
            chk(pm_sel_n == 1'b0, "R5 select low during access", pm_sel_n, 0);
            chk(pm_rd_n == v.wr, "R7 read strobe", pm_rd_n, v.wr);
            chk(pm_wr_n == !v.wr, "R7 write strobe", pm_wr_n, !v.wr);
            chk(pm_dout_en == v.wr, "R8 bus drive enable", pm_dout_en, v.wr);
            chk(pm_addr == v.addr, "R11 address held", pm_addr, v.addr);
            chk(rsp_ready == (k == int'(v.ws)), "R5 ready only in final cycle", rsp_ready, (k == int'(v.ws)));
            if (v.wr)
                chk(pm_bus == v.exp_data, "R2 write word on bus", pm_bus, v.exp_data);
            else if (k == int'(v.ws))
                chk(rsp_rdata == v.exp_data, v.fe ? "R4 fetch word" : "R3 read data", rsp_rdata, v.exp_data);
            @(negedge clk);
            if (stray && k == 0) begin
                req_vld = 1'b0; xreg_ld = 1'b0;
            end
        end
        chk(pm_sel_n && pm_rd_n && pm_wr_n, "R9 strobes high after access", {pm_sel_n, pm_rd_n, pm_wr_n}, 3'b111);
        chk(pm_dout_en == 1'b0, "R8 no drive after access", pm_dout_en, 0);
        chk(xreg_q == v.exp_x, v.fe ? "R4 xreg kept on fetch" : "R3 xreg after access", xreg_q, v.exp_x);
        @(negedge clk);
        if (stray) begin
            for (int j = 0; j < 3; j++) begin
                chk(pm_sel_n == 1'b1, "R10 stray request ignored", pm_sel_n, 1);
                @(negedge clk);
            end
            chk(xreg_q == v.exp_x, "R12 load while busy ignored", xreg_q, v.exp_x);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pm_sel_n && pm_rd_n && pm_wr_n, "R1 strobes high in reset", {pm_sel_n, pm_rd_n, pm_wr_n}, 3'b111);
        chk(pm_dout_en == 1'b0, "R1 no drive in reset", pm_dout_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1, "R1 idle after reset", idle, 1);
        chk(xreg_q == 8'h00, "R1 xreg cleared", xreg_q, 0);
        chk(pm_sel_n == 1'b1, "R1 select high after reset", pm_sel_n, 1);

        // R6: first access uses the reset setting of 7 wait states
        run_access('{1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 14'h0042, 16'h0, 8'h0, 24'h13579B, 24'h13579B, 8'h00}, 1'b0);

        for (int i = 0; i < NV; i++) run_access(VEC[i], 1'b0);

        // R10/R12: stray request and xreg load during a fetch
        run_access('{1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 14'h0ABC, 16'h0, 8'h4D, 24'h2468AC, 24'h2468AC, 8'h4D}, 1'b1);

        // R9: a held request still sees a forced gap (ws=0): sel_n 0,1,1,0,1,1
        ws_set_vld = 1'b1; ws_set_val = 3'd0;
        @(negedge clk);
        ws_set_vld = 1'b0;
        mem_word = 24'h0F0F0F;
        req_vld = 1'b1; req_write = 1'b0; req_fetch = 1'b1; req_addr = 14'h0001;
        @(negedge clk);
        for (int j = 0; j < 6; j++) begin
            chk(pm_sel_n == ((j % 3) != 0), "R9 gap with held request", pm_sel_n, ((j % 3) != 0));
            if (j == 4) req_vld = 1'b0;
            @(negedge clk);
        end
        chk(pm_sel_n == 1'b1, "R10 no access after release", pm_sel_n, 1);

        finish_run();
    end
endmodule